// File: doc/BRIEF.md
# Synchronized Burst Clock Generator

This block generates three related waveforms from one system clock. Every edge on every output comes from a single programmable half-period timer. When a start pulse arrives, the block plays one burst. The first output normally sits high and drops low once per pulse slot. The second output normally sits low and rises in the same slots, on the same clock edges. The third output gives one high marker during a chosen half-period of the burst.

The length of a half-period has an integer part and a fractional part. A phase accumulator adds the fraction once per half-period. Whenever the sum carries out, that half-period is one system clock longer. This trades a jitter of one cycle for an average period that matches a target frequency which is not a whole multiple of the system clock. For example, at 200 MHz, an integer part of 12 and a fraction of 231/256 average out near 7.75 MHz.

Settings are written at any time into holding registers. A burst copies them when it starts, so a write made in the middle of a burst cannot shorten or stretch a pulse.

Top module: `burst_clkgen`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, `busy` is 0, `wave_a` is 1, `wave_b` is 0 and `wave_c` is 0. An ongoing burst is abandoned.
- R2: A `start` that is high at an edge while `busy` is 0 begins a burst at that same edge. `busy` rises, and the burst runs through 2·N half-periods numbered 0 upward. In even half-periods `wave_a`=0 and `wave_b`=1. In odd half-periods `wave_a`=1 and `wave_b`=0. Both outputs change on the same edge.
- R3: Half-period k lasts H + c_k system clocks, where H is the integer setting (0 is treated as 1). The accumulator is 8 bits wide by default and is zeroed at each burst start. For each half-period it computes acc+F, where F is the fraction setting. c_k is the carry out of that sum, and the low 8 bits become the new acc.
- R4: `wave_c` is 1 exactly during half-period index M, counting from 0. If M ≥ 2·N, `wave_c` stays 0 for the whole burst.
- R5: At the edge that ends the last half-period, `busy` falls and all outputs return to their idle levels together.
- R6: A `start` that arrives while `busy` is 1 is ignored. The current burst continues unchanged.
- R7: Writes use `cfg_sel` with these codes: 0 sets H, 1 sets F, 2 sets N and 3 sets M. A write made during a burst does not change that burst. The new value applies from the next burst start.
- R8: After reset the settings are H=12, F=231, N=4 and M=6, which places the marker on the last pulse slot. A setting of N=0 is treated as N=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the setting selected by cfg_sel |
| cfg_sel | input | 2 | Setting select: 0 H, 1 F, 2 N, 3 M |
| cfg_wdata | input | CNT_W (16) | Write value, low bits used per field |
| start | input | 1 | Burst request, accepted only while idle |
| busy | output | 1 | High from an accepted start until outputs are idle |
| wave_a | output | 1 | Idle-high output, low-going pulses |
| wave_b | output | 1 | Idle-low output, high-going pulses |
| wave_c | output | 1 | Idle-low single marker pulse |

## Verification
The bench compares every cycle of each burst against a model of the accumulator that it builds itself. It covers these cases:
- A fraction that carries on every other half-period.
- A fraction that carries almost every time.
- An integer setting of zero.
- A pulse count of zero.
- A marker index beyond the burst, and a marker on the very last slot.

A design whose carry goes to the wrong half-period, or that does not clear the accumulator, would shift edges by one cycle. A design whose count is off by one would add or drop a slot.

Directed tests do three things:
- They pulse `start` in the middle of a burst. A design that restarts would show up as a changed waveform.
- They write new settings in the middle of a burst. A design without holding registers would bend the current pulses.
- They assert reset in the middle of a burst, to make sure the outputs go idle at once.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    // Levels of the three outputs during one half-period
    typedef struct packed {
        logic a;
        logic b;
        logic c;
    } lvl_t;

    localparam lvl_t LVL_IDLE = '{a: 1'b1, b: 1'b0, c: 1'b0};

    // Setting select codes
    typedef enum logic [1:0] {
        SEL_HALF  = 2'd0,
        SEL_FRAC  = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_MARK  = 2'd3
    } sel_e;

    // Even slots are the pulse phase (a low, b high); odd slots rest
    function automatic lvl_t slot_level(input logic odd, input logic hit);
        lvl_t l;
        l.a = odd;
        l.b = ~odd;
        l.c = hit;
        return l;
    endfunction

endpackage

// File: rtl/bcg_cfg.sv
module bcg_cfg
    import bcg_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int FRAC_W   = 8,
    parameter int NUM_W    = 4,
    parameter int IDX_W    = NUM_W + 1,
    parameter int DEF_HALF = 12,
    parameter int DEF_FRAC = 231,
    parameter int DEF_NUM  = 4,
    parameter int DEF_MARK = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [CNT_W-1:0]  wdata,
    input  logic              go,
    input  logic              busy,
    output logic [CNT_W-1:0]  half_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic [NUM_W-1:0]  num_o,
    output logic [IDX_W-1:0]  mark_o
);

    // Holding registers (software-visible) and per-burst active copies
    logic [CNT_W-1:0]  sh_half, act_half, sh_half_c;
    logic [FRAC_W-1:0] sh_frac, act_frac;
    logic [NUM_W-1:0]  sh_num,  act_num,  sh_num_c;
    logic [IDX_W-1:0]  sh_mark, act_mark;

    assign sh_half_c = (sh_half == '0) ? CNT_W'(1) : sh_half;
    assign sh_num_c  = (sh_num  == '0) ? NUM_W'(1) : sh_num;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_half <= CNT_W'(DEF_HALF);
            sh_frac <= FRAC_W'(DEF_FRAC);
            sh_num  <= NUM_W'(DEF_NUM);
            sh_mark <= IDX_W'(DEF_MARK);
        end else if (we) begin
            case (sel_e'(sel))
                SEL_HALF:  sh_half <= wdata;
                SEL_FRAC:  sh_frac <= wdata[FRAC_W-1:0];
                SEL_COUNT: sh_num  <= wdata[NUM_W-1:0];
                default:   sh_mark <= wdata[IDX_W-1:0];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_half <= CNT_W'(1);
            act_frac <= '0;
            act_num  <= NUM_W'(1);
            act_mark <= '0;
        end else if (go) begin
            act_half <= sh_half_c;
            act_frac <= sh_frac;
            act_num  <= sh_num_c;
            act_mark <= sh_mark;
        end
    end

    // The burst-start edge already sees the freshly latched values
    assign half_o = go ? sh_half_c : act_half;
    assign frac_o = go ? sh_frac   : act_frac;
    assign num_o  = go ? sh_num_c  : act_num;
    assign mark_o = go ? sh_mark   : act_mark;

    // R7: settings seen by the burst stay fixed while it runs
    a_r7_hold_in_burst: assert property (@(posedge clk) disable iff (rst)
        (busy && !go) |=> (!busy || ($stable(half_o) && $stable(frac_o)
                                     && $stable(num_o) && $stable(mark_o))));

endmodule

// File: rtl/bcg_timer.sv
module bcg_timer #(
    parameter int CNT_W  = 16,
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              busy,
    input  logic [CNT_W-1:0]  half,
    input  logic [FRAC_W-1:0] frac,
    output logic              tick
);

    logic [FRAC_W-1:0] acc;
    logic [CNT_W-1:0]  cnt, lim;
    logic [FRAC_W:0]   sum;
    logic              reload;

    // Phase accumulator restarts from zero on each burst start
    assign sum    = {1'b0, (go ? '0 : acc)} + {1'b0, frac};
    assign tick   = busy && (cnt == lim);
    assign reload = go || tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            cnt <= '0;
            lim <= '0;
        end else if (reload) begin
            acc <= sum[FRAC_W-1:0];
            lim <= half - CNT_W'(1) + CNT_W'(sum[FRAC_W]);
            cnt <= '0;
        end else if (busy) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R3: the counter never runs past the half-period limit
    a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt <= lim));

    // R3: a tick always restarts the count
    a_r3_tick_restart: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == '0));

endmodule

// File: rtl/bcg_seq.sv
module bcg_seq
    import bcg_pkg::*;
#(
    parameter int NUM_W = 4,
    parameter int IDX_W = NUM_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             tick,
    input  logic [NUM_W-1:0] num,
    input  logic [IDX_W-1:0] mark,
    output logic             busy,
    output lvl_t             lvl
);

    logic [IDX_W-1:0] idx, last, nxt;

    assign last = {num, 1'b0} - IDX_W'(1);
    assign nxt  = idx + IDX_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx  <= '0;
            busy <= 1'b0;
            lvl  <= LVL_IDLE;
        end else if (go) begin
            idx  <= '0;
            busy <= 1'b1;
            lvl  <= slot_level(1'b0, mark == '0);
        end else if (tick) begin
            if (idx == last) begin
                busy <= 1'b0;
                lvl  <= LVL_IDLE;
            end else begin
                idx <= nxt;
                lvl <= slot_level(nxt[0], mark == nxt);
            end
        end
    end

    // R5: idle levels whenever no burst runs
    a_r5_idle_levels: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (lvl == LVL_IDLE));

    // R2: the two pulse outputs stay complementary during a burst
    a_r2_complement: assert property (@(posedge clk) disable iff (rst)
        busy |-> (lvl.b == !lvl.a));

    // R4: the marker only appears inside a burst
    a_r4_marker_in_burst: assert property (@(posedge clk) disable iff (rst)
        lvl.c |-> busy);

    // R6: a start during a burst does not end it early
    a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> busy);

endmodule

// File: rtl/burst_clkgen.sv
module burst_clkgen
    import bcg_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int FRAC_W   = 8,
    parameter int NUM_W    = 4,
    parameter int DEF_HALF = 12,
    parameter int DEF_FRAC = 231,
    parameter int DEF_NUM  = 4,
    parameter int DEF_MARK = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic             start,
    output logic             busy,
    output logic             wave_a,
    output logic             wave_b,
    output logic             wave_c
);

    localparam int IDX_W = NUM_W + 1;

    logic [CNT_W-1:0]  half;
    logic [FRAC_W-1:0] frac;
    logic [NUM_W-1:0]  num;
    logic [IDX_W-1:0]  mark;
    logic              go, tick, busy_i;
    lvl_t              lvl;

    assign go = start && !busy_i;

    bcg_cfg #(
        .CNT_W(CNT_W), .FRAC_W(FRAC_W), .NUM_W(NUM_W), .IDX_W(IDX_W),
        .DEF_HALF(DEF_HALF), .DEF_FRAC(DEF_FRAC),
        .DEF_NUM(DEF_NUM), .DEF_MARK(DEF_MARK)
    ) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .go(go), .busy(busy_i),
        .half_o(half), .frac_o(frac), .num_o(num), .mark_o(mark)
    );

    bcg_timer #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_timer (
        .clk(clk), .rst(rst), .go(go), .busy(busy_i),
        .half(half), .frac(frac), .tick(tick)
    );

    bcg_seq #(.NUM_W(NUM_W), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst(rst), .go(go), .tick(tick),
        .num(num), .mark(mark), .busy(busy_i), .lvl(lvl)
    );

    assign busy   = busy_i;
    assign wave_a = lvl.a;
    assign wave_b = lvl.b;
    assign wave_c = lvl.c;

    // R1: outputs are idle on the cycle after reset
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (wave_a && !wave_b && !wave_c && !busy));

endmodule

// File: tb/tb_burst_clkgen.sv
module tb_burst_clkgen;

    localparam int FW = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        start = 1'b0;
    logic        busy, wave_a, wave_b, wave_c;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    burst_clkgen dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .start(start), .busy(busy),
        .wave_a(wave_a), .wave_b(wave_b), .wave_c(wave_c)
    );

    // Vector table: H, F, N, M (values before clamping)
    localparam int NV = 6;
    localparam int TH [NV] = '{3, 2, 1, 4, 0, 5};
    localparam int TF [NV] = '{0, 128, 255, 64, 100, 17};
    localparam int TN [NV] = '{2, 3, 1, 4, 0, 15};
    localparam int TM [NV] = '{2, 0, 0, 9, 1, 29};

    task automatic check(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {busy, wave_a, wave_b, wave_c};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: busy/a/b/c actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    task automatic wr(input int sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = 16'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Runs one burst and compares every cycle with the computed waveform.
    // poke: cycle at which a stray start is raised (-1 none).
    // wcyc: cycle at which sel/val is written (-1 none).
    task automatic burst(input int h, input int f, input int n, input int m,
                         input int poke, input int wcyc, input int wsel, input int wval,
                         input string tag);
        int hc, nc, acc, cyc;
        hc  = (h == 0) ? 1 : h;
        nc  = (n == 0) ? 1 : n;
        acc = 0;
        cyc = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int k = 0; k < 2 * nc; k++) begin
            int s, cr;
            s   = acc + f;
            cr  = s >> FW;
            acc = s & ((1 << FW) - 1);
            for (int j = 0; j < hc + cr; j++) begin
                check(tag, {1'b1, (k % 2 == 1), (k % 2 == 0), (k == m)});
                if (cyc == poke) start = 1'b1;
                if (cyc == wcyc) begin
                    cfg_we = 1'b1; cfg_sel = 2'(wsel); cfg_wdata = 16'(wval);
                end
                cyc++;
                @(negedge clk);
                start  = 1'b0;
                cfg_we = 1'b0;
            end
        end
        check({tag, " R5 end idle"}, 4'b0100);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 in reset", 4'b0100);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", 4'b0100);

        // R8: default settings H=12 F=231 N=4 M=6
        burst(12, 231, 4, 6, -1, -1, 0, 0, "R8 defaults R2 R3 R4");

        // Table walk: R2 R3 R4 R5, plus R8 clamps of H=0 and N=0
        for (int v = 0; v < NV; v++) begin
            wr(0, TH[v]); wr(1, TF[v]); wr(2, TN[v]); wr(3, TM[v]);
            burst(TH[v], TF[v], TN[v], TM[v], -1, -1, 0, 0, "R2 R3 R4 table");
        end

        // R6: start raised mid-burst is ignored
        wr(0, 3); wr(1, 128); wr(2, 3); wr(3, 5);
        burst(3, 128, 3, 5, 4, -1, 0, 0, "R6 start while busy");
        burst(3, 128, 3, 5, 10, -1, 0, 0, "R6 start while busy late");

        // R7: write during burst is deferred to the next burst
        burst(3, 128, 3, 5, -1, 2, 0, 2, "R7 burst unchanged by write");
        burst(2, 128, 3, 5, -1, 3, 2, 2, "R7 new H applied");
        burst(2, 128, 2, 5, -1, -1, 0, 0, "R7 new N applied");

        // R1: reset in mid-burst returns to idle at once
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid-burst", 4'b0100);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle after reset", 4'b0100);
        // R8: defaults restored by reset
        burst(12, 231, 4, 6, -1, -1, 0, 0, "R8 defaults after reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule